// File: doc/BRIEF.md
# Multicore Start-PC and Halt Controller

This block lets a master core launch secondary cores at a chosen start address. The host drives a small write/read bus with two registers behind it. The parameter register holds a staged value. The command register takes a word that names an operation and a target core. Each core gets three outputs from the block: a start-PC value, a one-cycle load strobe, and a halt level.

To bring up a core, the host first writes the start address into the parameter register. It then issues a write-PC command for that core, followed by a separate clear-halt command. A set-halt command stops a core again. An out-of-range core index or an unknown opcode changes nothing except a sticky error flag, which only reset clears.

Top module: `core_launch_ctrl`

## Requirements
- R1: On reset, halt_o equals HALT_RST. The default HALT_RST has core 0 running and every other core halted. All start-PC outputs, all load strobes and err_o are 0.
- R2: A write with addr_i=0 loads wdata_i into the parameter register. While addr_i=0, rdata_o shows the last value written. While addr_i=1, rdata_o is 0.
- R3: A write with addr_i=1 is a command. Bits 7:0 are the opcode and bits 15:8 are the core index. All higher bits are ignored.
- R4: Opcode 8'h01 (write-PC) copies the parameter register into the indexed core's start-PC output. The new value appears in the cycle after the write. Other cores keep their values.
- R5: A write-PC raises pc_load_o for the indexed core for exactly one cycle, the cycle after the write. No other core's strobe rises.
- R6: Opcode 8'h02 (clear-halt) drops halt_o of the indexed core from the cycle after the write.
- R7: Opcode 8'h03 (set-halt) raises halt_o of the indexed core from the cycle after the write.
- R8: Any other opcode sets err_o and leaves every core output unchanged.
- R9: A core index of NUM_CORES or more sets err_o and leaves every core output unchanged.
- R10: err_o stays set until reset.
- R11: Writing the parameter register after a write-PC does not change any start-PC output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 1 | Register select: 0 parameter, 1 command |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| start_pc_o | output | NUM_CORES*DATA_W | Start PC per core, core n at bits n*DATA_W upward |
| pc_load_o | output | NUM_CORES | One-cycle start-PC load strobe per core |
| halt_o | output | NUM_CORES | Halt level per core |
| err_o | output | 1 | Sticky command error |

## Verification
The bench builds the block with NUM_CORES=5, DATA_W=32 and the default halt reset pattern. Five is not a power of two, so indices 5 to 7 are out of range even though they fit in the same three index bits as legal ones. The bench also uses indices up to 255. Random commands carry noise in the upper bits. The bench mixes legal and illegal opcodes. Parameter writes are interleaved with commands, so staged values can change between a write-PC and later commands.

// File: rtl/launch_pkg.sv
package launch_pkg;
  localparam int unsigned IDX_LSB = 8;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned OP_W    = 8;
  typedef enum logic [OP_W-1:0] {
    OP_WRITE_PC   = 8'h01,
    OP_CLEAR_HALT = 8'h02,
    OP_SET_HALT   = 8'h03
  } launch_op_e;
endpackage

// File: rtl/launch_cmd_dec.sv
module launch_cmd_dec
  import launch_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 cmd_vld_i,
  input  logic [DATA_W-1:0]    cmd_i,
  output logic [NUM_CORES-1:0] wr_pc_o,
  output logic [NUM_CORES-1:0] clr_o,
  output logic [NUM_CORES-1:0] set_o,
  output logic                 err_o
);
  logic [OP_W-1:0]      op;
  logic [IDX_W-1:0]     idx;
  logic                 idx_ok, op_ok;
  logic [NUM_CORES-1:0] hit;

  assign op     = cmd_i[OP_W-1:0];
  assign idx    = cmd_i[IDX_LSB +: IDX_W];
  assign idx_ok = {1'b0, idx} < (IDX_W+1)'(NUM_CORES);
  assign op_ok  = (op == OP_WRITE_PC) || (op == OP_CLEAR_HALT) || (op == OP_SET_HALT);
  assign err_o  = cmd_vld_i && !(idx_ok && op_ok);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_hit
    assign hit[g]     = cmd_vld_i && idx_ok && (idx == IDX_W'(g));
    assign wr_pc_o[g] = hit[g] && (op == OP_WRITE_PC);
    assign clr_o[g]   = hit[g] && (op == OP_CLEAR_HALT);
    assign set_o[g]   = hit[g] && (op == OP_SET_HALT);
  end

  always_comb begin
    if (!$isunknown({wr_pc_o, clr_o, set_o, err_o})) begin
      AST_DEC_EXCL: assert (!(err_o && |{wr_pc_o, clr_o, set_o})); // R8
      AST_DEC_ONEHOT: assert ($onehot0({wr_pc_o, clr_o, set_o})); // R3
    end
  end
endmodule

// File: rtl/launch_core_slot.sv
module launch_core_slot #(
  parameter int unsigned DATA_W    = 32,
  parameter logic        HALT_INIT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_pc_i,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] param_i,
  output logic [DATA_W-1:0] pc_o,
  output logic              load_o,
  output logic              halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      load_o <= 1'b0;
      halt_o <= HALT_INIT;
    end else begin
      load_o <= wr_pc_i;
      if (wr_pc_i) pc_o <= param_i;
      if (clr_i) halt_o <= 1'b0;
      else if (set_i) halt_o <= 1'b1;
    end
  end

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pc_i |=> $stable(pc_o)); // R11
  AST_LOAD_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pc_i |=> (load_o && pc_o == $past(param_i))); // R4
  AST_CLR_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !halt_o); // R6
  AST_SET_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> halt_o); // R7
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i || set_i) |=> $stable(halt_o)); // R8
endmodule

// File: rtl/core_launch_ctrl.sv
module core_launch_ctrl #(
  parameter int unsigned          NUM_CORES = 4,
  parameter int unsigned          DATA_W    = 32,
  parameter logic [NUM_CORES-1:0] HALT_RST  = {{(NUM_CORES-1){1'b1}}, 1'b0}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic                        addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_CORES*DATA_W-1:0] start_pc_o,
  output logic [NUM_CORES-1:0]        pc_load_o,
  output logic [NUM_CORES-1:0]        halt_o,
  output logic                        err_o
);
  logic [DATA_W-1:0]    param_q;
  logic [NUM_CORES-1:0] wr_pc, clr, set;
  logic                 cmd_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param_q <= '0;
      err_o   <= 1'b0;
    end else begin
      if (wr_en_i && !addr_i) param_q <= wdata_i;
      if (cmd_err) err_o <= 1'b1;
    end
  end

  assign rdata_o = addr_i ? '0 : param_q;

  launch_cmd_dec #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) i_dec (
    .cmd_vld_i (wr_en_i && addr_i),
    .cmd_i     (wdata_i),
    .wr_pc_o   (wr_pc),
    .clr_o     (clr),
    .set_o     (set),
    .err_o     (cmd_err)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    launch_core_slot #(.DATA_W(DATA_W), .HALT_INIT(HALT_RST[g])) i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_pc_i (wr_pc[g]),
      .clr_i   (clr[g]),
      .set_i   (set[g]),
      .param_i (param_q),
      .pc_o    (start_pc_o[g*DATA_W +: DATA_W]),
      .load_o  (pc_load_o[g]),
      .halt_o  (halt_o[g])
    );
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R10
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err |=> err_o); // R9
  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pc_load_o)); // R5
  AST_PARAM_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> (param_q == $past(wdata_i))); // R2
endmodule

// File: tb/test_core_launch_ctrl.sv
module test_core_launch_ctrl;
  localparam int NC = 5;
  localparam int DW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_en_i = 1'b0, addr_i = 1'b0;
  logic [DW-1:0]    wdata_i = '0;
  logic [DW-1:0]    rdata_o;
  logic [NC*DW-1:0] start_pc_o;
  logic [NC-1:0]    pc_load_o, halt_o;
  logic             err_o;

  int tests = 0, fails = 0;
  logic [NC*DW-1:0] e_pc;
  logic [NC-1:0]    e_halt, e_load;
  logic             e_err;
  logic [DW-1:0]    e_param;

  always #2.5 clk_i = ~clk_i;

  core_launch_ctrl #(.NUM_CORES(NC), .DATA_W(DW)) i_core_launch_ctrl (.*);

  task automatic chk(string req, logic [NC*DW-1:0] act, logic [NC*DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // model of one command write, per requirements R3..R9
  function automatic void model_cmd(logic [DW-1:0] d);
    logic [7:0] op  = d[7:0];
    logic [7:0] idx = d[15:8];
    e_load = '0;
    if (idx >= NC || op < 8'h01 || op > 8'h03) e_err = 1'b1;
    else case (op)
      8'h01: begin e_pc[idx*DW +: DW] = e_param; e_load[idx] = 1'b1; end
      8'h02: e_halt[idx] = 1'b0;
      default: e_halt[idx] = 1'b1;
    endcase
  endfunction

  task automatic bus_wr(logic a, logic [DW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 1'b0;
    if (a) model_cmd(d); else begin e_param = d; e_load = '0; end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R4 pc"}, start_pc_o, e_pc);
    chk({tag, " R5 load"}, NC*DW'(pc_load_o), NC*DW'(e_load));
    chk({tag, " R6 R7 halt"}, NC*DW'(halt_o), NC*DW'(e_halt));
    chk({tag, " R10 err"}, NC*DW'(err_o), NC*DW'(e_err));
  endtask

  task automatic cmd(logic [7:0] op, logic [7:0] idx, logic [15:0] noise, string tag);
    bus_wr(1'b1, {noise, idx, op});
    check_all(tag);
    @(negedge clk_i);
    e_load = '0;
    chk({tag, " R5 strobe drop"}, NC*DW'(pc_load_o), '0);
  endtask

  initial begin
    e_pc = '0; e_halt = 5'b11110; e_load = '0; e_err = 1'b0; e_param = '0;
    void'($urandom(32'd4242));
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 reset");

    bus_wr(1'b0, 32'h8000_1000);
    chk("R2 param read", NC*DW'(rdata_o), NC*DW'(32'h8000_1000));
    addr_i = 1'b1; #1;
    chk("R2 cmd read zero", NC*DW'(rdata_o), '0);
    addr_i = 1'b0;

    cmd(8'h01, 8'd1, 16'hABCD, "R3 R4 wpc core1");
    cmd(8'h02, 8'd1, 16'h0000, "R6 clr core1");
    bus_wr(1'b0, 32'h1234_5678);
    check_all("R11 param after wpc");
    cmd(8'h01, 8'd4, 16'h0000, "R4 wpc last core");
    cmd(8'h03, 8'd0, 16'h0000, "R7 set core0");
    cmd(8'h01, 8'd5, 16'h0000, "R9 idx=NC");
    cmd(8'h02, 8'd255, 16'h0000, "R9 idx 255");
    cmd(8'h00, 8'd2, 16'h0000, "R8 op 00");
    cmd(8'h04, 8'd2, 16'h0000, "R8 op 04");
    cmd(8'h02, 8'd2, 16'h0000, "R10 err stays");

    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(3) == 0) bus_wr(1'b0, $urandom());
      cmd(($urandom_range(7) == 0) ? 8'($urandom()) : 8'($urandom_range(3, 1)),
          ($urandom_range(9) == 0) ? 8'($urandom()) : 8'($urandom_range(7)),
          16'($urandom()), "R3 random");
    end

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    e_pc = '0; e_halt = 5'b11110; e_load = '0; e_err = 1'b0; e_param = '0;
    check_all("R1 re-reset");
    chk("R1 param reset", NC*DW'(rdata_o), '0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule